// File: doc/BRIEF.md
# Reserving Tag Controller for a Non-Blocking Set-Associative Cache

This block holds the tag and per-way status of a set-associative data cache that keeps accepting requests while misses are still in flight. Each way carries a tag, a valid flag, a reserved flag and a dirty flag, plus two timestamps: when the line was last touched and when it was brought in. A request presents an address and a read/write flag. One cycle after it is accepted, the block returns a single result code, and, when a line has to be pushed out, the line address of the way it gave up.

A read miss in write-back mode claims a way at once by marking it reserved, so that the returning data has a place to land. Later requests to that line are reported as hits on a pending miss. When every way of the set is already claimed, the request is refused and the requester has to retry. A separate fill port turns a reserved way into a valid line when its data returns. In a write-through build, a fill with no matching reservation installs the line directly. A fill and a request aimed at the same set in the same cycle are serialized: the fill is taken and the request is held off.

Top module: `rsv_tag_array`

## Requirements
- R1: A synchronous active-high reset clears the valid, reserved and dirty flags of every way and drops `rsp_valid`. The first read to any line after reset therefore reports code 3 (miss, no writeback).
- R2: Each accepted request (`req_valid` and `req_ready` both high at a clock edge) produces exactly one response, with `rsp_valid` high in the following cycle. In any cycle that follows no accepted request, `rsp_valid` is low.
- R3: A request whose tag matches a way that is valid and not reserved reports code 0 (hit) in a write-back build and code 1 (write-through hit) in a write-through build. It refreshes that way's last-used time, and it sets dirty when the request is a write.
- R4: A request whose tag matches a reserved way reports code 2 (hit on pending miss), and the way stays reserved. A write of this kind also sets dirty.
- R5: A write miss, or any miss in a write-through build, reports code 3 and allocates nothing. A following read miss to the same line is again a miss.
- R6: A read miss in a write-back build, where the set has a way that is neither valid nor reserved, reserves the lowest-numbered such way, stores the new tag there and reports code 3.
- R7: A write-back read miss to a set whose ways are all reserved reports code 5 (reservation failure) and changes no state.
- R8: A write-back read miss with no free way, where not every way is reserved, reports code 4 (miss with writeback). The victim becomes reserved only, with the new tag. `rsp_wb_addr` carries the victim's old line address: the old tag, then the set index, then zero offset bits.
- R9: The victim is the valid, unreserved way with the smallest last-used time when LRU is selected, or the smallest fetch time when FIFO is selected. A tie goes to the lowest-numbered way.
- R10: A fill whose tag matches a reserved way of its set clears reserved, sets valid and stamps both times with the current cycle, so that the next request to that line hits. In a write-back build, a fill with no matching reserved way has no effect.
- R11: While `fill_valid` is high and `fill_addr` and `req_addr` select the same set, `req_ready` is low and the request is not accepted. For different sets, `req_ready` is high.
- R12: In a write-through build, a fill with no reserved match and no valid match installs the line as valid. It uses the lowest free way, or otherwise the policy victim, and reports nothing. A write-through build never reports code 4 or code 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Request byte address |
| req_ready | output | 1 | Request can be accepted this cycle |
| fill_valid | input | 1 | Line data has returned for `fill_addr` |
| fill_addr | input | ADDR_W | Byte address of the returning line |
| rsp_valid | output | 1 | Result of the request accepted one cycle earlier |
| rsp_code | output | 3 | Result code 0..5 as listed in the requirements |
| rsp_wb_addr | output | ADDR_W | Evicted line address when code is 4, else zero |

## Verification
The bench builds three copies with the default geometry: a 16-bit address, 4-byte lines, 4 sets and 4 ways. Two of them are write-back, one with LRU and one with FIFO replacement, and they receive identical stimulus. The third is write-through with LRU. With only four ways, five tags aimed at one set are enough to use up every reservation, to force evictions, and to make the LRU and FIFO copies pick different victims from the same history. The write-through copy reaches the code 1 hit and the install-on-fill path that the write-back copies cannot.

// File: rtl/rsvtag_pkg.sv
package rsvtag_pkg;

  typedef enum logic [2:0] {
    RSP_HIT        = 3'd0,
    RSP_HIT_WT     = 3'd1,
    RSP_HIT_PEND   = 3'd2,
    RSP_MISS       = 3'd3,
    RSP_MISS_EVICT = 3'd4,
    RSP_RSV_FAIL   = 3'd5
  } rsp_code_e;

endpackage

// File: rtl/rsvtag_match.sv
// Per-way tag compare and status classification for one set.
module rsvtag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 12
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_vld,
  input  logic [WAYS-1:0]            way_rsv,
  input  logic [TAG_W-1:0]           look_tag,
  output logic                       hit_any,
  output logic [$clog2(WAYS)-1:0]    hit_way,
  output logic                       pend_any,
  output logic [$clog2(WAYS)-1:0]    pend_way,
  output logic                       free_any,
  output logic [$clog2(WAYS)-1:0]    free_way,
  output logic                       all_rsv,
  output logic [WAYS-1:0]            cand
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] hit_v;
  logic [WAYS-1:0] pend_v;
  logic [WAYS-1:0] free_v;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic tag_eq;
    assign tag_eq    = (way_tag[g] == look_tag);
    assign hit_v[g]  = tag_eq & way_vld[g] & ~way_rsv[g];
    assign pend_v[g] = tag_eq & way_rsv[g];
    assign free_v[g] = ~way_vld[g] & ~way_rsv[g];
    assign cand[g]   = way_vld[g] & ~way_rsv[g];
  end

  assign hit_any  = |hit_v;
  assign pend_any = |pend_v;
  assign free_any = |free_v;
  assign all_rsv  = &way_rsv;

  // lowest-numbered way wins each search
  always_comb begin
    hit_way  = '0;
    pend_way = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_v[w])  hit_way  = WAY_W'(w);
      if (pend_v[w]) pend_way = WAY_W'(w);
      if (free_v[w]) free_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/rsvtag_pick.sv
// Replacement choice: oldest stamp among candidate ways, ties to lowest way.
module rsvtag_pick #(
  parameter int WAYS = 4,
  parameter int TS_W = 16
) (
  input  logic [WAYS-1:0]           cand,
  input  logic [WAYS-1:0][TS_W-1:0] stamp,
  output logic                      found,
  output logic [$clog2(WAYS)-1:0]   way
);
  localparam int WAY_W = $clog2(WAYS);

  logic [TS_W-1:0] best;

  always_comb begin
    found = 1'b0;
    way   = '0;
    best  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (cand[w] && (!found || (stamp[w] < best))) begin
        found = 1'b1;
        way   = WAY_W'(w);
        best  = stamp[w];
      end
    end
  end

endmodule

// File: rtl/rsv_tag_array.sv
module rsv_tag_array
  import rsvtag_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 2,
  parameter int SET_W      = 2,
  parameter int WAYS       = 4,
  parameter int TS_W       = 16,
  parameter int WRITE_BACK = 1,
  parameter int USE_LRU    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              rsp_valid,
  output logic [2:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_wb_addr
);
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);

  // tag and status storage, one packed word per set
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            vld_q   [SETS];
  logic [WAYS-1:0]            rsv_q   [SETS];
  logic [WAYS-1:0]            dty_q   [SETS];
  logic [WAYS-1:0][TS_W-1:0]  used_q  [SETS];
  logic [WAYS-1:0][TS_W-1:0]  fetch_q [SETS];
  logic [TS_W-1:0]            now_q;

  logic unused_offset_bits;
  assign unused_offset_bits = ^{req_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

  // ---------------- request side ----------------
  logic [SET_W-1:0] r_set;
  logic [TAG_W-1:0] r_tag;
  assign r_set = req_addr[OFF_W +: SET_W];
  assign r_tag = req_addr[ADDR_W-1 -: TAG_W];

  logic             rq_hit, rq_pend, rq_free, rq_all_rsv, rq_found;
  logic [WAY_W-1:0] rq_hit_way, rq_pend_way, rq_free_way, rq_pick_way;
  logic [WAYS-1:0]  rq_cand;
  logic [WAYS-1:0][TS_W-1:0] rq_stamp;

  rsvtag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_req_match (
    .way_tag  (tag_q[r_set]),
    .way_vld  (vld_q[r_set]),
    .way_rsv  (rsv_q[r_set]),
    .look_tag (r_tag),
    .hit_any  (rq_hit),
    .hit_way  (rq_hit_way),
    .pend_any (rq_pend),
    .pend_way (rq_pend_way),
    .free_any (rq_free),
    .free_way (rq_free_way),
    .all_rsv  (rq_all_rsv),
    .cand     (rq_cand)
  );

  // ---------------- fill side ----------------
  logic [SET_W-1:0] f_set;
  logic [TAG_W-1:0] f_tag;
  assign f_set = fill_addr[OFF_W +: SET_W];
  assign f_tag = fill_addr[ADDR_W-1 -: TAG_W];

  logic             fl_hit, fl_pend, fl_free, fl_found, fl_unused_all;
  logic [WAY_W-1:0] fl_unused_hit_way, fl_pend_way, fl_free_way, fl_pick_way;
  logic [WAYS-1:0]  fl_cand;
  logic [WAYS-1:0][TS_W-1:0] fl_stamp;

  rsvtag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_match (
    .way_tag  (tag_q[f_set]),
    .way_vld  (vld_q[f_set]),
    .way_rsv  (rsv_q[f_set]),
    .look_tag (f_tag),
    .hit_any  (fl_hit),
    .hit_way  (fl_unused_hit_way),
    .pend_any (fl_pend),
    .pend_way (fl_pend_way),
    .free_any (fl_free),
    .free_way (fl_free_way),
    .all_rsv  (fl_unused_all),
    .cand     (fl_cand)
  );

  // replacement stamp source chosen by policy
  if (USE_LRU != 0) begin : g_lru
    assign rq_stamp = used_q[r_set];
    assign fl_stamp = used_q[f_set];
  end else begin : g_fifo
    assign rq_stamp = fetch_q[r_set];
    assign fl_stamp = fetch_q[f_set];
  end

  rsvtag_pick #(.WAYS(WAYS), .TS_W(TS_W)) u_req_pick (
    .cand  (rq_cand),
    .stamp (rq_stamp),
    .found (rq_found),
    .way   (rq_pick_way)
  );

  rsvtag_pick #(.WAYS(WAYS), .TS_W(TS_W)) u_fill_pick (
    .cand  (fl_cand),
    .stamp (fl_stamp),
    .found (fl_found),
    .way   (fl_pick_way)
  );

  // fill has priority over a request to the same set
  assign req_ready = !(fill_valid && (f_set == r_set));

  logic accept;
  assign accept = req_valid && req_ready;

  // ---------------- request decision ----------------
  rsp_code_e        r_code;
  logic [WAY_W-1:0] r_way;
  logic             r_touch, r_dirty, r_alloc, r_evict;

  always_comb begin
    r_code  = RSP_MISS;
    r_way   = '0;
    r_touch = 1'b0;
    r_dirty = 1'b0;
    r_alloc = 1'b0;
    r_evict = 1'b0;
    if (rq_hit) begin
      r_code  = (WRITE_BACK != 0) ? RSP_HIT : RSP_HIT_WT;
      r_way   = rq_hit_way;
      r_touch = 1'b1;
      r_dirty = req_write;
    end else if (rq_pend) begin
      r_code  = RSP_HIT_PEND;
      r_way   = rq_pend_way;
      r_dirty = req_write;
    end else if ((WRITE_BACK == 0) || req_write) begin
      r_code  = RSP_MISS;
    end else if (rq_all_rsv) begin
      r_code  = RSP_RSV_FAIL;
    end else if (rq_free) begin
      r_code  = RSP_MISS;
      r_way   = rq_free_way;
      r_alloc = 1'b1;
    end else if (rq_found) begin
      r_code  = RSP_MISS_EVICT;
      r_way   = rq_pick_way;
      r_alloc = 1'b1;
      r_evict = 1'b1;
    end
  end

  logic [ADDR_W-1:0] r_victim_addr;
  assign r_victim_addr = {tag_q[r_set][r_way], r_set, {OFF_W{1'b0}}};

  // ---------------- fill decision ----------------
  logic             f_upd, f_install;
  logic [WAY_W-1:0] f_way;

  always_comb begin
    f_upd     = 1'b0;
    f_install = 1'b0;
    f_way     = '0;
    if (fill_valid) begin
      if (fl_pend) begin
        f_upd = 1'b1;
        f_way = fl_pend_way;
      end else if ((WRITE_BACK == 0) && !fl_hit) begin
        if (fl_free) begin
          f_upd     = 1'b1;
          f_install = 1'b1;
          f_way     = fl_free_way;
        end else if (fl_found) begin
          f_upd     = 1'b1;
          f_install = 1'b1;
          f_way     = fl_pick_way;
        end
      end
    end
  end

  // ---------------- state update ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      now_q       <= '0;
      rsp_valid   <= 1'b0;
      rsp_code    <= RSP_HIT;
      rsp_wb_addr <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]   <= '0;
        rsv_q[s]   <= '0;
        dty_q[s]   <= '0;
        tag_q[s]   <= '0;
        used_q[s]  <= '0;
        fetch_q[s] <= '0;
      end
    end else begin
      now_q     <= now_q + 1'b1;
      rsp_valid <= accept;

      if (f_upd) begin
        vld_q[f_set][f_way]   <= 1'b1;
        rsv_q[f_set][f_way]   <= 1'b0;
        used_q[f_set][f_way]  <= now_q;
        fetch_q[f_set][f_way] <= now_q;
        if (f_install) begin
          tag_q[f_set][f_way] <= f_tag;
          dty_q[f_set][f_way] <= 1'b0;
        end
      end

      if (accept) begin
        rsp_code    <= r_code;
        rsp_wb_addr <= r_evict ? r_victim_addr : '0;
        if (r_touch) used_q[r_set][r_way] <= now_q;
        if (r_dirty) dty_q[r_set][r_way]  <= 1'b1;
        if (r_alloc) begin
          tag_q[r_set][r_way] <= r_tag;
          rsv_q[r_set][r_way] <= 1'b1;
          vld_q[r_set][r_way] <= 1'b0;
          dty_q[r_set][r_way] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/rsvtag_chk.sv
module rsvtag_chk #(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 2,
  parameter int SET_W      = 2,
  parameter int WRITE_BACK = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              rsp_valid,
  input logic [2:0]        rsp_code,
  input logic [ADDR_W-1:0] rsp_wb_addr
);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  assert_wb_line_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 3'd4) |->
      (rsp_wb_addr[OFF_W-1:0] == '0) &&
      (rsp_wb_addr[OFF_W +: SET_W] == $past(req_addr[OFF_W +: SET_W])));

  assert_write_no_alloc_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_write)) |-> (rsp_code != 3'd4 && rsp_code != 3'd5));

  assert_mode_codes_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((WRITE_BACK != 0) ? (rsp_code != 3'd1 && rsp_code <= 3'd5)
                                     : (rsp_code <= 3'd3)));

  assert_set_serial_R11: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && req_valid && req_ready) |->
      (fill_addr[OFF_W +: SET_W] != req_addr[OFF_W +: SET_W]));

endmodule

bind rsv_tag_array rsvtag_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .WRITE_BACK(WRITE_BACK)
) u_rsvtag_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_ready(req_ready), .fill_valid(fill_valid),
  .fill_addr(fill_addr), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .rsp_wb_addr(rsp_wb_addr)
);

// File: tb/rsv_tag_array_test.sv
module rsv_tag_array_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, fill_valid = 1'b0;
  logic [15:0] req_addr = '0, fill_addr = '0;
  logic        w_req_valid = 1'b0, w_req_write = 1'b0, w_fill_valid = 1'b0;
  logic [15:0] w_req_addr = '0, w_fill_addr = '0;

  logic        rdy_l, vld_l, rdy_f, vld_f, rdy_w, vld_w;
  logic [2:0]  code_l, code_f, code_w;
  logic [15:0] wb_l, wb_f, wb_w;

  rsv_tag_array #(.USE_LRU(1), .WRITE_BACK(1)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(rdy_l), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .rsp_valid(vld_l), .rsp_code(code_l), .rsp_wb_addr(wb_l));

  rsv_tag_array #(.USE_LRU(0), .WRITE_BACK(1)) uut_fifo (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(rdy_f), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .rsp_valid(vld_f), .rsp_code(code_f), .rsp_wb_addr(wb_f));

  rsv_tag_array #(.USE_LRU(1), .WRITE_BACK(0)) uut_wt (
    .clk(clk), .rst(rst), .req_valid(w_req_valid), .req_write(w_req_write),
    .req_addr(w_req_addr), .req_ready(rdy_w), .fill_valid(w_fill_valid),
    .fill_addr(w_fill_addr), .rsp_valid(vld_w), .rsp_code(code_w), .rsp_wb_addr(wb_w));

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input int rq, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  // vector: fill op, write, address, code, check wb, wb (LRU), wb (FIFO), requirement
  typedef struct packed {
    logic        fill;
    logic        wr;
    logic [15:0] addr;
    logic [2:0]  code;
    logic        cw;
    logic [15:0] wb;
    logic [15:0] wbf;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0,1'b0,16'h0104,3'd3,1'b0,16'h0000,16'h0000,4'd6},  // R1 R6 first read reserves way0
    '{1'b0,1'b0,16'h0104,3'd2,1'b0,16'h0000,16'h0000,4'd4},  // R4 read on pending line
    '{1'b0,1'b1,16'h0104,3'd2,1'b0,16'h0000,16'h0000,4'd4},  // R4 write on pending line
    '{1'b0,1'b1,16'h0204,3'd3,1'b0,16'h0000,16'h0000,4'd5},  // R5 write miss, no allocation
    '{1'b0,1'b0,16'h0204,3'd3,1'b0,16'h0000,16'h0000,4'd5},  // R5 still a miss, now reserves way1
    '{1'b0,1'b0,16'h0304,3'd3,1'b0,16'h0000,16'h0000,4'd6},  // R6 way2
    '{1'b0,1'b0,16'h0404,3'd3,1'b0,16'h0000,16'h0000,4'd6},  // R6 way3
    '{1'b0,1'b0,16'h0504,3'd5,1'b0,16'h0000,16'h0000,4'd7},  // R7 all reserved
    '{1'b0,1'b0,16'h0504,3'd5,1'b0,16'h0000,16'h0000,4'd7},  // R7 unchanged, fails again
    '{1'b0,1'b0,16'h0304,3'd2,1'b0,16'h0000,16'h0000,4'd7},  // R7 reservation kept
    '{1'b1,1'b0,16'h0104,3'd0,1'b0,16'h0000,16'h0000,4'd10}, // R10 fill way0
    '{1'b0,1'b0,16'h0104,3'd0,1'b0,16'h0000,16'h0000,4'd10}, // R10 hit after fill
    '{1'b1,1'b0,16'h0204,3'd0,1'b0,16'h0000,16'h0000,4'd10},
    '{1'b1,1'b0,16'h0304,3'd0,1'b0,16'h0000,16'h0000,4'd10},
    '{1'b1,1'b0,16'h0404,3'd0,1'b0,16'h0000,16'h0000,4'd10},
    '{1'b1,1'b0,16'h0704,3'd0,1'b0,16'h0000,16'h0000,4'd10}, // R10 unmatched fill ignored
    '{1'b0,1'b0,16'h0104,3'd0,1'b0,16'h0000,16'h0000,4'd3},  // R3 read hit, way0 newest use
    '{1'b0,1'b0,16'h0704,3'd4,1'b1,16'h0204,16'h0104,4'd9},  // R9 R8 LRU vs FIFO victim
    '{1'b0,1'b0,16'h0704,3'd2,1'b0,16'h0000,16'h0000,4'd8},  // R8 victim now reserved
    '{1'b0,1'b0,16'h0804,3'd4,1'b1,16'h0304,16'h0204,4'd9},  // R9 second eviction
    '{1'b0,1'b1,16'h0404,3'd0,1'b0,16'h0000,16'h0000,4'd3},  // R3 write hit
    '{1'b0,1'b0,16'h0108,3'd3,1'b0,16'h0000,16'h0000,4'd6}   // R6 other set independent
  };

  task automatic do_req(input logic w, input logic [15:0] a, input logic [2:0] ec,
                        input logic cw, input logic [15:0] ewb, input logic [15:0] ewbf, input int rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(2, "rsp_valid lru", {15'd0, vld_l}, 16'd1);   // R2
    chk(2, "rsp_valid fifo", {15'd0, vld_f}, 16'd1);
    chk(rq, "code lru", {13'd0, code_l}, {13'd0, ec});
    chk(rq, "code fifo", {13'd0, code_f}, {13'd0, ec});
    if (cw) begin
      chk(rq, "wb lru", wb_l, ewb);
      chk(rq, "wb fifo", wb_f, ewbf);
    end
  endtask

  task automatic do_fill(input logic [15:0] a);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic wt_req(input logic w, input logic [15:0] a, input logic [2:0] ec, input int rq);
    @(negedge clk);
    w_req_valid = 1'b1; w_req_write = w; w_req_addr = a;
    @(negedge clk);
    w_req_valid = 1'b0; w_req_write = 1'b0;
    chk(2, "rsp_valid wt", {15'd0, vld_w}, 16'd1);
    chk(rq, "code wt", {13'd0, code_w}, {13'd0, ec});
  endtask

  task automatic wt_fill(input logic [15:0] a);
    @(negedge clk);
    w_fill_valid = 1'b1; w_fill_addr = a;
    @(negedge clk);
    w_fill_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    chk(1, "rsp_valid after reset lru", {15'd0, vld_l}, 16'd0);
    chk(1, "rsp_valid after reset wt", {15'd0, vld_w}, 16'd0);
    chk(11, "ready idle", {15'd0, rdy_l}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].fill) do_fill(VECS[i].addr);
      else do_req(VECS[i].wr, VECS[i].addr, VECS[i].code, VECS[i].cw,
                  VECS[i].wb, VECS[i].wbf, int'(VECS[i].rq));
    end

    // R11 fill and request to the same set in one cycle
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = 16'h0804;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0904;
    #1;
    chk(11, "ready same set lru", {15'd0, rdy_l}, 16'd0);
    chk(11, "ready same set fifo", {15'd0, rdy_f}, 16'd0);
    @(negedge clk);
    chk(11, "no rsp while held", {15'd0, vld_l}, 16'd0);   // R2 no response
    fill_valid = 1'b0;
    #1;
    chk(11, "ready after fill", {15'd0, rdy_l}, 16'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(11, "held request code lru", {13'd0, code_l}, 16'd4);
    chk(11, "held request code fifo", {13'd0, code_f}, 16'd4);
    chk(9, "held request wb lru", wb_l, 16'h0104);
    chk(9, "held request wb fifo", wb_f, 16'h0304);
    // R11 different sets do not block
    fill_valid = 1'b1; fill_addr = 16'h0008; req_addr = 16'h0004;
    #1;
    chk(11, "ready other set", {15'd0, rdy_l}, 16'd1);
    @(negedge clk);
    fill_valid = 1'b0;

    // R1 reset in mid-run clears every line
    do_reset();
    chk(1, "rsp_valid after second reset", {15'd0, vld_l}, 16'd0);
    do_req(1'b0, 16'h0104, 3'd3, 1'b0, 16'h0, 16'h0, 1);
    do_req(1'b0, 16'h0104, 3'd2, 1'b0, 16'h0, 16'h0, 1);

    // R12 write-through build
    wt_req(1'b0, 16'h0104, 3'd3, 5);      // R5 miss, no allocation
    wt_req(1'b0, 16'h0104, 3'd3, 5);
    wt_fill(16'h0104);                    // R12 installs way0
    wt_req(1'b0, 16'h0104, 3'd1, 3);      // R3 write-through hit
    wt_req(1'b1, 16'h0204, 3'd3, 5);
    wt_req(1'b0, 16'h0204, 3'd3, 5);
    wt_fill(16'h0204);
    wt_fill(16'h0304);
    wt_fill(16'h0404);
    wt_req(1'b1, 16'h0204, 3'd1, 3);
    wt_fill(16'h0504);                    // R12 replaces least recent way0
    wt_req(1'b0, 16'h0504, 3'd1, 12);
    wt_req(1'b0, 16'h0104, 3'd3, 12);
    wt_req(1'b0, 16'h0904, 3'd3, 12);     // R12 full set miss, no code 4 or 5

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule